// File: doc/BRIEF.md
# Programmable Synchronous Bus-Cycle Timing Generator

This block is the master side of a synchronous, non-multiplexed parallel memory bus. A single read or write request from the internal side becomes one bus access: a chip select, an address-valid strobe, an output enable for reads and a write enable for writes, all active-low, together with a bus clock at half the functional clock rate. The bus clock runs only while an access is in progress.

Every strobe edge, the tick at which read data is sampled, the spacing of further burst words and the total access length are configuration inputs that count whole bus-clock ticks. These inputs are latched when an access starts, so they may change freely while it runs. Read words are sampled on rising bus-clock edges and handed back one at a time, each with a one-cycle valid pulse. A done pulse marks the return to idle. When the device is declared 8 bits wide, the block makes single accesses only, whatever the burst setting.

Tick numbering: tick t of an access occupies two functional-clock cycles. The bus clock is low in the first cycle and high in the second, so each tick begins on a falling edge and has its rising edge in the middle.

Top module: `bus_cycle_timer`

## Requirements
- R1: After reset and while idle, `bus_cs_n`, `bus_adv_n`, `bus_oe_n` and `bus_we_n` are high. `bus_clk`, `bus_dout_en`, `rd_valid` and `done` are low.
- R2: During an access, `bus_clk` is low in the first functional-clock cycle of each tick and high in the second. Strobes change only at tick boundaries, never while `bus_clk` is high.
- R3: `bus_cs_n` is low from tick 0 up to, but not including, the chip-select end tick. That tick is taken from `cfg_cs_off_rd` for reads and from `cfg_cs_off_wr` for writes.
- R4: `bus_adv_n` is low from tick 0 up to, but not including, `cfg_adv_off_rd` for reads or `cfg_adv_off_wr` for writes.
- R5: On reads only, `bus_oe_n` is low for the ticks t with `cfg_oe_on` <= t < `cfg_oe_off`. It stays high throughout writes.
- R6: On writes only, `bus_we_n` is low for the ticks t with `cfg_we_on` <= t < `cfg_we_off`. It stays high throughout reads. Output enable and write enable are never low together.
- R7: The first read word is `bus_din` as sampled on the rising bus-clock edge of tick `cfg_first`. It appears on `rd_data` with `rd_valid` high for exactly the one cycle that follows that edge.
- R8: In burst mode (`cfg_burst`=1), the block returns `cfg_words`+1 words (1 to 8). Word j is sampled at tick `cfg_first` + j*`cfg_step`, and a step of 0 counts as 1. A word whose tick falls at or after the end of the access is not returned.
- R9: When `cfg_dev8`=1, or when `cfg_burst`=0, exactly one word is returned per read, regardless of `cfg_words`.
- R10: An access lasts L ticks (2L functional clocks). L is `cfg_len_rd` for reads and `cfg_len_wr` for writes, and a value of 0 counts as 1. `done` is high for one cycle, directly after the last tick, with all strobes already high.
- R11: `req` is acted on only while idle; a request during an access is dropped. All configuration fields, the direction, the address and the write data are taken at the start of an access. Later changes to those inputs do not affect the access in progress.
- R12: `bus_addr` holds the request address for the whole access. On writes, `bus_dout` holds the write data and `bus_dout_en` is high for every cycle of the access. On reads `bus_dout_en` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Start an access (taken when idle) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| cfg_cs_off_rd | input | TW | Chip-select end tick, reads |
| cfg_cs_off_wr | input | TW | Chip-select end tick, writes |
| cfg_adv_off_rd | input | TW | Address-valid end tick, reads |
| cfg_adv_off_wr | input | TW | Address-valid end tick, writes |
| cfg_oe_on | input | TW | Output-enable start tick |
| cfg_oe_off | input | TW | Output-enable end tick |
| cfg_we_on | input | TW | Write-enable start tick |
| cfg_we_off | input | TW | Write-enable end tick |
| cfg_first | input | TW | Tick at which the first read word is sampled |
| cfg_step | input | TW | Ticks between burst words (0 counts as 1) |
| cfg_len_rd | input | TW | Read access length in ticks |
| cfg_len_wr | input | TW | Write access length in ticks |
| cfg_burst | input | 1 | Burst read enable |
| cfg_dev8 | input | 1 | 8-bit device; forces single access |
| cfg_words | input | LW | Burst words minus one |
| bus_clk | output | 1 | Bus clock, half rate, runs only during an access |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_adv_n | output | 1 | Address valid, active low |
| bus_oe_n | output | 1 | Output enable, active low |
| bus_we_n | output | 1 | Write enable, active low |
| bus_addr | output | AW | Address to the bus |
| bus_dout | output | DW | Write data to the bus |
| bus_dout_en | output | 1 | Drive enable for bus_dout |
| bus_din | input | DW | Read data from the bus |
| rd_data | output | DW | Sampled read word |
| rd_valid | output | 1 | One-cycle valid for rd_data |
| done | output | 1 | One-cycle pulse when the access ends |

## Verification
The tick and phase counters are internal, but any error in them shows up on the ports within one functional cycle. A wrong tick shifts an edge of `bus_cs_n`, `bus_adv_n`, `bus_oe_n` or `bus_we_n` by two cycles. A wrong phase inverts `bus_clk` at once. Because the bench drives `bus_din` with a different value on every tick, a wrong sample tick or burst counter shows up as a wrong `rd_data` value or a misplaced `rd_valid` pulse. Configuration that was not latched diverges from the expected waveform in the first cycle after the bench scrambles the inputs. A request that should have been dropped would leave chip select low during the idle cycles that follow `done`.

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int TW = 5,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [TW-1:0] cfg_cs_off_rd,
  input  logic [TW-1:0] cfg_cs_off_wr,
  input  logic [TW-1:0] cfg_adv_off_rd,
  input  logic [TW-1:0] cfg_adv_off_wr,
  input  logic [TW-1:0] cfg_oe_on,
  input  logic [TW-1:0] cfg_oe_off,
  input  logic [TW-1:0] cfg_we_on,
  input  logic [TW-1:0] cfg_we_off,
  input  logic [TW-1:0] cfg_first,
  input  logic [TW-1:0] cfg_step,
  input  logic [TW-1:0] cfg_len_rd,
  input  logic [TW-1:0] cfg_len_wr,
  input  logic          cfg_burst,
  input  logic          cfg_dev8,
  input  logic [LW-1:0] cfg_words,
  output logic          bus_clk,
  output logic          bus_cs_n,
  output logic          bus_adv_n,
  output logic          bus_oe_n,
  output logic          bus_we_n,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  output logic          bus_dout_en,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          done
);
  localparam int CW = TW + 1;

  logic          act, ph, we_r;
  logic [TW-1:0] tk;
  logic [TW-1:0] l_cs, l_adv, l_oe_on, l_oe_off, l_we_on, l_we_off, l_len, l_step;
  logic [CW-1:0] cap;
  logic [LW:0]   left;

  logic          nx_act, nx_ph;
  logic [TW-1:0] nx_tk;

  wire           start   = !act && req;
  wire  [CW-1:0] tk_inc  = {1'b0, tk} + CW'(1);
  wire           ends    = act && ph && (tk_inc >= {1'b0, l_len});
  wire           cap_hit = act && !ph && !we_r && (left != '0) && ({1'b0, tk} == cap);

  wire           e_we     = act ? we_r     : req_we;
  wire  [TW-1:0] e_cs     = act ? l_cs     : (req_we ? cfg_cs_off_wr  : cfg_cs_off_rd);
  wire  [TW-1:0] e_adv    = act ? l_adv    : (req_we ? cfg_adv_off_wr : cfg_adv_off_rd);
  wire  [TW-1:0] e_oe_on  = act ? l_oe_on  : cfg_oe_on;
  wire  [TW-1:0] e_oe_off = act ? l_oe_off : cfg_oe_off;
  wire  [TW-1:0] e_we_on  = act ? l_we_on  : cfg_we_on;
  wire  [TW-1:0] e_we_off = act ? l_we_off : cfg_we_off;

  wire           single   = cfg_dev8 || !cfg_burst;
  wire  [LW:0]   n_words  = single ? (LW+1)'(1) : ({1'b0, cfg_words} + (LW+1)'(1));

  always_comb begin
    nx_act = act;
    nx_tk  = tk;
    nx_ph  = ph;
    if (!act) begin
      if (req) begin
        nx_act = 1'b1;
        nx_tk  = '0;
        nx_ph  = 1'b0;
      end
    end else if (!ph) begin
      nx_ph = 1'b1;
    end else begin
      nx_ph = 1'b0;
      if (ends) nx_act = 1'b0;
      else      nx_tk  = tk_inc[TW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act         <= 1'b0;
      ph          <= 1'b0;
      tk          <= '0;
      we_r        <= 1'b0;
      bus_clk     <= 1'b0;
      bus_cs_n    <= 1'b1;
      bus_adv_n   <= 1'b1;
      bus_oe_n    <= 1'b1;
      bus_we_n    <= 1'b1;
      bus_dout_en <= 1'b0;
      bus_addr    <= '0;
      bus_dout    <= '0;
      rd_data     <= '0;
      rd_valid    <= 1'b0;
      done        <= 1'b0;
      l_cs        <= '0;
      l_adv       <= '0;
      l_oe_on     <= '0;
      l_oe_off    <= '0;
      l_we_on     <= '0;
      l_we_off    <= '0;
      l_len       <= '0;
      l_step      <= '0;
      cap         <= '0;
      left        <= '0;
    end else begin
      act         <= nx_act;
      ph          <= nx_ph;
      tk          <= nx_tk;
      bus_clk     <= nx_act && nx_ph;
      bus_cs_n    <= !(nx_act && (nx_tk < e_cs));
      bus_adv_n   <= !(nx_act && (nx_tk < e_adv));
      bus_oe_n    <= !(nx_act && !e_we && (nx_tk >= e_oe_on) && (nx_tk < e_oe_off));
      bus_we_n    <= !(nx_act &&  e_we && (nx_tk >= e_we_on) && (nx_tk < e_we_off));
      bus_dout_en <= nx_act && e_we;
      done        <= ends;
      rd_valid    <= cap_hit;
      if (cap_hit) begin
        rd_data <= bus_din;
        cap     <= cap + {1'b0, l_step};
        left    <= left - (LW+1)'(1);
      end
      if (start) begin
        we_r     <= req_we;
        bus_addr <= req_addr;
        bus_dout <= req_wdata;
        l_cs     <= e_cs;
        l_adv    <= e_adv;
        l_oe_on  <= cfg_oe_on;
        l_oe_off <= cfg_oe_off;
        l_we_on  <= cfg_we_on;
        l_we_off <= cfg_we_off;
        l_len    <= req_we ? cfg_len_wr : cfg_len_rd;
        l_step   <= (cfg_step == '0) ? TW'(1) : cfg_step;
        cap      <= {1'b0, cfg_first};
        left     <= n_words;
      end
    end
  end
endmodule

// File: rtl/bus_cycle_timer_chk.sv
module bus_cycle_timer_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_clk,
  input logic bus_cs_n,
  input logic bus_adv_n,
  input logic bus_oe_n,
  input logic bus_we_n,
  input logic bus_dout_en,
  input logic rd_valid,
  input logic done
);
  // R2
  clk_high_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_clk |=> !bus_clk);
  // R2
  edge_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(bus_cs_n) || !$stable(bus_adv_n) || !$stable(bus_oe_n) || !$stable(bus_we_n)) |-> !bus_clk);
  // R6
  oe_we_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_oe_n && !bus_we_n));
  // R12
  drive_vs_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_dout_en |-> bus_oe_n);
  // R7
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (bus_cs_n && bus_adv_n && bus_oe_n && bus_we_n && !bus_clk && !bus_dout_en));
endmodule

bind bus_cycle_timer bus_cycle_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_cs_n(bus_cs_n),
  .bus_adv_n(bus_adv_n), .bus_oe_n(bus_oe_n), .bus_we_n(bus_we_n),
  .bus_dout_en(bus_dout_en), .rd_valid(rd_valid), .done(done)
);

// File: tb/bus_cycle_timer_bench.sv
module bus_cycle_timer_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0;
  logic [15:0] req_addr = '0, req_wdata = '0, bus_din = '0;
  logic [4:0] c_cs_rd = '0, c_cs_wr = '0, c_adv_rd = '0, c_adv_wr = '0;
  logic [4:0] c_oe_on = '0, c_oe_off = '0, c_we_on = '0, c_we_off = '0;
  logic [4:0] c_first = '0, c_step = '0, c_len_rd = '0, c_len_wr = '0;
  logic c_burst = 1'b0, c_dev8 = 1'b0;
  logic [2:0] c_words = '0;
  logic bus_clk, bus_cs_n, bus_adv_n, bus_oe_n, bus_we_n, bus_dout_en, rd_valid, done;
  logic [15:0] bus_addr, bus_dout, rd_data;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bus_cycle_timer u_bus_cycle_timer (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .cfg_cs_off_rd(c_cs_rd), .cfg_cs_off_wr(c_cs_wr),
    .cfg_adv_off_rd(c_adv_rd), .cfg_adv_off_wr(c_adv_wr), .cfg_oe_on(c_oe_on),
    .cfg_oe_off(c_oe_off), .cfg_we_on(c_we_on), .cfg_we_off(c_we_off),
    .cfg_first(c_first), .cfg_step(c_step), .cfg_len_rd(c_len_rd), .cfg_len_wr(c_len_wr),
    .cfg_burst(c_burst), .cfg_dev8(c_dev8), .cfg_words(c_words),
    .bus_clk(bus_clk), .bus_cs_n(bus_cs_n), .bus_adv_n(bus_adv_n), .bus_oe_n(bus_oe_n),
    .bus_we_n(bus_we_n), .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
    .bus_din(bus_din), .rd_data(rd_data), .rd_valid(rd_valid), .done(done)
  );

  task automatic chk(input string tag, input logic [31:0] a, input logic [31:0] e);
    n_chk++;
    if (a !== e) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, a, e, $time);
    end
  endtask

  function automatic logic [15:0] din_of(input int seed, input int t);
    return 16'(seed * 16'h0137 + t * 16'h0111 + 16'h0a05);
  endfunction

  task automatic idle_checks(input string why);
    chk({why, " R1 cs_n"}, 32'(bus_cs_n), 1);
    chk({why, " R1 adv_n"}, 32'(bus_adv_n), 1);
    chk({why, " R1 oe_n"}, 32'(bus_oe_n), 1);
    chk({why, " R1 we_n"}, 32'(bus_we_n), 1);
    chk({why, " R1 bus_clk"}, 32'(bus_clk), 0);
    chk({why, " R1 dout_en"}, 32'(bus_dout_en), 0);
    chk({why, " R1 rd_valid"}, 32'(rd_valid), 0);
    chk({why, " R1 done"}, 32'(done), 0);
  endtask

  task automatic do_access(input bit w, input int len, input int first, input int step,
                           input int words, input int mode, input int i);
    int cs_off, adv_off, oe_on, oe_off, we_on, we_off, len_e, step_e, nw, t, ph;
    logic [15:0] a, d;
    bit burst, dev8, cap;
    burst = (mode != 1);
    dev8  = (mode == 2);
    len_e = (len == 0) ? 1 : len;
    cs_off  = i % (len_e + 2);
    adv_off = (i * 3) % (len_e + 2);
    oe_on   = i % 4;
    oe_off  = oe_on + 1 + (i % 5);
    we_on   = i % 2;
    we_off  = 2 + (i % 7);
    step_e  = (step == 0) ? 1 : step;
    nw      = (dev8 || !burst) ? 1 : words + 1;
    a = 16'(i * 16'h3b1 + 7);
    d = 16'(i * 16'h5a3 ^ 16'hc33c);
    @(negedge clk);
    req = 1'b1; req_we = w; req_addr = a; req_wdata = d;
    c_cs_rd  = w ? 5'(len_e + 3 - cs_off % 3) : 5'(cs_off);
    c_cs_wr  = w ? 5'(cs_off) : 5'(len_e + 3 - cs_off % 3);
    c_adv_rd = w ? 5'(adv_off + 5) : 5'(adv_off);
    c_adv_wr = w ? 5'(adv_off) : 5'(adv_off + 5);
    c_len_rd = w ? 5'(len + 3) : 5'(len);
    c_len_wr = w ? 5'(len) : 5'(len + 3);
    c_oe_on = 5'(oe_on); c_oe_off = 5'(oe_off);
    c_we_on = 5'(we_on); c_we_off = 5'(we_off);
    c_first = 5'(first); c_step = 5'(step); c_words = 3'(words);
    c_burst = burst; c_dev8 = dev8;
    @(posedge clk);
    @(negedge clk);
    // R11: scramble every input after acceptance
    req = 1'b0; req_we = ~w; req_addr = ~a; req_wdata = ~d;
    c_cs_rd = ~c_cs_rd; c_cs_wr = ~c_cs_wr; c_adv_rd = ~c_adv_rd; c_adv_wr = ~c_adv_wr;
    c_len_rd = ~c_len_rd; c_len_wr = ~c_len_wr; c_oe_on = ~c_oe_on; c_oe_off = ~c_oe_off;
    c_we_on = ~c_we_on; c_we_off = ~c_we_off; c_first = ~c_first; c_step = ~c_step;
    c_words = ~c_words; c_burst = ~c_burst; c_dev8 = ~c_dev8;
    for (int k = 0; k <= 2 * len_e; k++) begin
      t = k / 2; ph = k % 2;
      bus_din = din_of(i, t);
      if (k < 2 * len_e) begin
        chk("R2 bus_clk", 32'(bus_clk), 32'(ph));
        chk("R3 cs_n", 32'(bus_cs_n), 32'(!(t < cs_off)));
        chk("R4 adv_n", 32'(bus_adv_n), 32'(!(t < adv_off)));
        chk("R5 oe_n", 32'(bus_oe_n), 32'(!(!w && t >= oe_on && t < oe_off)));
        chk("R6 we_n", 32'(bus_we_n), 32'(!(w && t >= we_on && t < we_off)));
        chk("R10 done early", 32'(done), 0);
        chk("R12 addr", 32'(bus_addr), 32'(a));
        chk("R12 dout_en", 32'(bus_dout_en), 32'(w));
        if (w) chk("R12 dout", 32'(bus_dout), 32'(d));
        cap = 0;
        if (ph == 1 && !w && t >= first && ((t - first) % step_e) == 0 &&
            ((t - first) / step_e) < nw) cap = 1;
        chk(nw == 1 ? "R9 rd_valid" : "R8 rd_valid", 32'(rd_valid), 32'(cap));
        if (cap) chk(t == first ? "R7 rd_data" : "R8 rd_data", 32'(rd_data), 32'(din_of(i, t)));
      end else begin
        chk("R10 done", 32'(done), 1);
        chk("R10 cs_n at end", 32'(bus_cs_n), 1);
        chk("R10 bus_clk at end", 32'(bus_clk), 0);
      end
      if (k == 3) req = 1'b1;
      if (k == 4) req = 1'b0;
      @(negedge clk);
    end
    req = 1'b0;
    for (int j = 0; j < 3; j++) begin
      idle_checks("R11 dropped request");
      @(negedge clk);
    end
  endtask

  initial begin
    #600000;
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int i;
    i = 0;
    repeat (3) @(negedge clk);
    idle_checks("in reset");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    idle_checks("after reset");
    for (int w = 0; w < 2; w++)
      for (int first = 0; first < 4; first++)
        for (int step = 0; step < 3; step++)
          for (int wi = 0; wi < 3; wi++)
            for (int mode = 0; mode < 3; mode++) begin
              do_access(w[0], (i % 10 == 0) ? 0 : 3 + i % 9, first, step,
                        (wi == 0) ? 0 : (wi == 1) ? 2 : 7, mode, i);
              i++;
            end
    // R8: burst that outlasts the access; words past the end are not returned
    do_access(1'b0, 6, 2, 1, 7, 0, i);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule